// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 12-bit successive-approximation converter. It runs on a system clock. When the convert-start input rises, the block raises a busy flag and presets its result register to all ones. When convert-start drops again, the block starts a gated conversion clock. The clock runs one pulse per bit step, plus one pulse that loads the first trial code.

At each step the block drives a trial code on its parallel result bus, which also feeds the external feedback DAC. It then reads the external comparator and settles one bit. Bits are settled from the most significant downward. A trial bit is always driven to 0, and bits that have not been tested yet sit at 1.

After the last decision, the block waits a programmable number of system cycles and then drops busy. The result is already stable when busy falls, so the falling edge of busy can start a downstream transfer. Two further inputs shape the run. A resolution select can end the run early at 10 or 8 bits. A clock-inhibit input freezes the run while it is held high. The block also provides an inverted copy of the result MSB.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After synchronous reset, `busy_o` is 0, `data_o` is all ones, `msb_n_o` is 0 and `conv_clk_o` is 0.
- R2: A rising edge on `conv_start_i` while idle sets `busy_o` and loads all ones into `data_o` on the following clock edge. No conversion clock pulse appears while `conv_start_i` stays high.
- R3: The gated clock starts only after `conv_start_i` falls. A full-resolution run gives exactly 13 rising edges on `conv_clk_o`. `conv_clk_o` is 0 whenever `busy_o` is 0.
- R4: The first gated clock pulse loads the trial code with the MSB at 0 and every other bit at 1 (0x7FF for 12 bits).
- R5: At decision step n, bit n (counted from the MSB) takes the value of `cmp_i`, and bit n+1 is driven to 0 in the same edge. With a comparator that reports "analog input above the DAC code", the final result equals the input code.
- R6: `short_sel_i` is captured on the start rising edge: 01 selects 10 bits (11 clock pulses), 10 selects 8 bits (9 pulses), and 00 or 11 select 12 bits. Bits below the chosen resolution remain 1. Changing `short_sel_i` later has no effect on the running conversion.
- R7: While `clk_inhibit_i` is high during a run, `conv_clk_o` stays 0 and `data_o` does not change. Releasing it resumes the run, which then gives the same result and the same pulse count.
- R8: `busy_o` falls exactly STATUS_DLY system cycles after the last rising edge of `conv_clk_o`, and `data_o` does not change on that edge.
- R9: A new rising edge on `conv_start_i` while `busy_o` is high is ignored: result and pulse count are unaffected.
- R10: `msb_n_o` always equals the inverse of `data_o[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_i | input | 1 | Convert-start pulse; rising edge arms, falling edge runs |
| clk_inhibit_i | input | 1 | High freezes the conversion clock |
| short_sel_i | input | 2 | Resolution select (00/11: 12 bits, 01: 10, 10: 8) |
| cmp_i | input | 1 | Comparator level: 1 = analog input above DAC code |
| busy_o | output | 1 | High while converting; low means result valid |
| data_o | output | W | Parallel result and DAC trial code |
| msb_n_o | output | 1 | Inverted result MSB |
| conv_clk_o | output | 1 | Gated conversion clock, low when idle |

## Verification
The properties assume that the comparator is a combinational function of the current trial code and settles within one system cycle. They also assume that convert-start is low for the whole run, apart from the deliberate single-cycle re-starts. The bench computes `cmp_i` directly from `data_o` and a target code, so that assumption holds by construction. It drives every input at the falling clock edge. Clock inhibit and the resolution select are randomised only at points where the requirements permit it: inhibit after start has fallen, and select both before and after capture.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } sar_state_e;

  // number of bits resolved for a given resolution select code
  function automatic int res_bits(input logic [1:0] sel, input int full,
                                  input int mid, input int low);
    case (sel)
      2'b01:   return mid;
      2'b10:   return low;
      default: return full;
    endcase
  endfunction

endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int STEP_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic inhibit_i,
  output logic tick_o,
  output logic conv_clk_o
);
  localparam int CW = (STEP_DIV > 2) ? $clog2(STEP_DIV) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(STEP_DIV - 1);
  localparam logic [CW-1:0] HALF_C = CW'(STEP_DIV / 2);

  logic [CW-1:0] cnt_q;
  logic          clk_q;

  assign tick_o     = run_i && !inhibit_i && (cnt_q == '0);
  assign conv_clk_o = clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      if (!run_i) begin
        cnt_q <= '0;
      end else if (!inhibit_i) begin
        cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
      end
      // rising edge only together with a step; high phase continues to HALF
      clk_q <= run_i && !inhibit_i &&
               ((cnt_q == '0) || (clk_q && (cnt_q < HALF_C)));
    end
  end
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int W  = 12,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [IW-1:0] step_i,
  input  logic [IW-1:0] last_i,
  input  logic          cmp_i,
  output logic [W-1:0]  data_o,
  output logic          msb_n_o
);
  logic [W-1:0] data_q;
  logic [W-1:0] nxt;

  always_comb begin
    nxt = data_q;
    if (clear_i) begin
      nxt = '1;
    end else if (tick_i) begin
      if (step_i == '0) begin
        nxt        = '1;
        nxt[W-1]   = 1'b0;
      end else begin
        for (int b = 0; b < W; b++) begin
          if (b == W - int'(step_i))
            nxt[b] = cmp_i;
          if ((b == W - 1 - int'(step_i)) && (step_i != last_i))
            nxt[b] = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '1;
      msb_n_o <= 1'b0;
    end else begin
      data_q  <= nxt;
      msb_n_o <= ~nxt[W-1];
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int W          = 12,
  parameter int RES_MID    = 10,
  parameter int RES_LOW    = 8,
  parameter int STATUS_DLY = 1,
  parameter int IW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic [1:0]    sel_i,
  output logic          run_o,
  output logic          busy_o,
  output logic          clear_o,
  output logic [IW-1:0] step_o,
  output logic [IW-1:0] last_o
);
  localparam int DW = (STATUS_DLY > 1) ? $clog2(STATUS_DLY) : 1;
  localparam logic [DW-1:0] DLY_LAST = DW'(STATUS_DLY - 1);

  sar_state_e    state_q;
  logic          start_q;
  logic [DW-1:0] dly_q;
  logic          rise;

  assign rise    = start_i && !start_q;
  assign clear_o = (state_q == ST_IDLE) && rise;
  assign run_o   = (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      busy_o  <= 1'b0;
      step_o  <= '0;
      last_o  <= IW'(W);
      dly_q   <= '0;
    end else begin
      start_q <= start_i;
      case (state_q)
        ST_IDLE: begin
          if (rise) begin
            busy_o  <= 1'b1;
            last_o  <= IW'(res_bits(sel_i, W, RES_MID, RES_LOW));
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (!start_i) begin
            step_o  <= '0;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (step_o == last_o) begin
              dly_q   <= '0;
              state_q <= ST_HOLD;
            end else begin
              step_o <= step_o + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (dly_q == DLY_LAST) begin
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int W          = 12,
  parameter int RES_MID    = 10,
  parameter int RES_LOW    = 8,
  parameter int STEP_DIV   = 4,
  parameter int STATUS_DLY = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         conv_start_i,
  input  logic         clk_inhibit_i,
  input  logic [1:0]   short_sel_i,
  input  logic         cmp_i,
  output logic         busy_o,
  output logic [W-1:0] data_o,
  output logic         msb_n_o,
  output logic         conv_clk_o
);
  localparam int IW = $clog2(W + 1);

  logic          run;
  logic          tick;
  logic          clear;
  logic [IW-1:0] step;
  logic [IW-1:0] last;

  sar_seq #(
    .W(W), .RES_MID(RES_MID), .RES_LOW(RES_LOW),
    .STATUS_DLY(STATUS_DLY), .IW(IW)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(conv_start_i), .tick_i(tick),
    .sel_i(short_sel_i), .run_o(run), .busy_o(busy_o), .clear_o(clear),
    .step_o(step), .last_o(last)
  );

  sar_step_timer #(.STEP_DIV(STEP_DIV)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .inhibit_i(clk_inhibit_i),
    .tick_o(tick), .conv_clk_o(conv_clk_o)
  );

  sar_bit_reg #(.W(W), .IW(IW)) u_bits (
    .clk(clk), .rst(rst), .clear_i(clear), .tick_i(tick), .step_i(step),
    .last_i(last), .cmp_i(cmp_i), .data_o(data_o), .msb_n_o(msb_n_o)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         conv_start_i,
  input logic         clk_inhibit_i,
  input logic         busy_o,
  input logic [W-1:0] data_o,
  input logic         msb_n_o,
  input logic         conv_clk_o
);
  // R2: start edge while idle raises busy
  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(conv_start_i) && !busy_o) |=> busy_o);

  // R3: no conversion clock while idle
  p_clk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !conv_clk_o);

  // R7: inhibit freezes result and clock
  p_inhibit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (clk_inhibit_i && busy_o) |=> ($stable(data_o) && !conv_clk_o));

  // R8: result already stable when busy drops
  p_stable_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $stable(data_o));

  // R10: inverted MSB output tracks the result
  p_msb_inv_r10: assert property (@(posedge clk) disable iff (rst)
    msb_n_o == ~data_o[W-1]);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .conv_start_i(conv_start_i),
  .clk_inhibit_i(clk_inhibit_i), .busy_o(busy_o), .data_o(data_o),
  .msb_n_o(msb_n_o), .conv_clk_o(conv_clk_o)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;
  localparam int W   = 12;
  localparam int DLY = 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         inhibit = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] x_val = '0;
  logic         cmp;
  logic         busy;
  logic [W-1:0] data;
  logic         msb_n;
  logic         cclk;
  int           cyc = 0;
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // comparator: analog input above DAC trial code
  assign cmp = (x_val > data);

  sar_conv_ctrl #(.W(W), .STATUS_DLY(DLY)) i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .conv_start_i(start), .clk_inhibit_i(inhibit),
    .short_sel_i(sel), .cmp_i(cmp), .busy_o(busy), .data_o(data),
    .msb_n_o(msb_n), .conv_clk_o(cclk)
  );

  function automatic int res_of(input logic [1:0] s);
    return (s == 2'b01) ? 10 : (s == 2'b10) ? 8 : 12;
  endfunction

  function automatic logic [W-1:0] exp_code(input logic [W-1:0] x, input logic [1:0] s);
    logic [W-1:0] m;
    m = '0;
    for (int b = 0; b < W - res_of(s); b++) m[b] = 1'b1;
    return x | m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // runs one conversion starting at a falling clock edge
  task automatic convert(input logic [W-1:0] x, input logic [1:0] s, input int width,
                         input bit rnd_inh, input bit poke,
                         output logic [W-1:0] code, output int pulses,
                         output int gap, output bit inh_bad);
    int guard;
    int last_rise;
    logic prev_clk;
    logic prev_inh;
    logic [W-1:0] prev_data;
    bit poked;
    bit poking;
    x_val = x; sel = s; start = 1'b1;
    pulses = 0; guard = 0; last_rise = 0; prev_clk = 1'b0; prev_inh = 1'b0;
    inh_bad = 1'b0; poked = 1'b0; poking = 1'b0;
    for (int i = 0; i < width; i++) begin
      @(negedge clk);
      if (cclk) pulses++;
    end
    start = 1'b0;
    sel = 2'($urandom);
    prev_data = data;
    do begin
      @(negedge clk);
      guard++;
      if (cclk && !prev_clk) begin pulses++; last_rise = cyc; end
      prev_clk = cclk;
      if (prev_inh && ((data !== prev_data) || cclk)) inh_bad = 1'b1;
      prev_data = data;
      inhibit = rnd_inh ? (($urandom % 3) == 0) : 1'b0;
      prev_inh = inhibit;
      if (poking) begin
        start = 1'b0; poking = 1'b0;
      end else if (poke && !poked && pulses == 3) begin
        start = 1'b1; poking = 1'b1; poked = 1'b1;
      end
    end while (busy === 1'b1 && guard < 5000);
    inhibit = 1'b0; start = 1'b0;
    gap = cyc - last_rise;
    code = data;
  endtask

  task automatic run_and_check(input logic [W-1:0] x, input logic [1:0] s,
                               input int width, input bit rnd_inh, input bit poke);
    logic [W-1:0] code;
    int pulses;
    int gap;
    bit ib;
    convert(x, s, width, rnd_inh, poke, code, pulses, gap, ib);
    chk(code == exp_code(x, s), "R5/R6", "result", int'(code), int'(exp_code(x, s)));
    chk(pulses == res_of(s) + 1, "R3/R6", "pulse count", pulses, res_of(s) + 1);
    chk(gap == DLY, "R8", "busy fall delay", gap, DLY);
    chk(msb_n == ~code[W-1], "R10", "inverted msb", int'(msb_n), int'(~code[W-1]));
    if (rnd_inh) chk(!ib, "R7", "inhibit freeze", int'(ib), 0);
    if (poke) chk(code == exp_code(x, s), "R9", "restart ignored", int'(code), int'(exp_code(x, s)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int g;
    int p;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(data == '1, "R1", "data", int'(data), 'hFFF);
    chk(msb_n == 1'b0, "R1", "msb_n", int'(msb_n), 0);
    chk(cclk == 1'b0, "R1", "clock", int'(cclk), 0);

    // corner codes, full resolution
    run_and_check(12'h000, 2'b00, 2, 1'b0, 1'b0);
    run_and_check(12'hFFF, 2'b00, 1, 1'b0, 1'b0);
    run_and_check(12'h800, 2'b00, 3, 1'b0, 1'b0);
    run_and_check(12'h7FF, 2'b00, 1, 1'b0, 1'b0);
    run_and_check(12'h000, 2'b00, 1, 1'b0, 1'b0);

    // R2 and R4 directed
    x_val = 12'h5A3; sel = 2'b00; start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    chk(data == '1, "R2", "preset ones", int'(data), 'hFFF);
    p = 0;
    repeat (4) begin @(negedge clk); if (cclk) p++; end
    chk(p == 0, "R2", "no clock while start high", p, 0);
    start = 1'b0;
    g = 0;
    while (!cclk && g < 100) begin @(negedge clk); g++; end
    chk(data == 12'h7FF, "R4", "first trial code", int'(data), 'h7FF);
    g = 0;
    while (busy && g < 1000) begin @(negedge clk); g++; end
    chk(data == 12'h5A3, "R5", "directed result", int'(data), 'h5A3);

    // R6 short cycle
    run_and_check(12'hABC, 2'b01, 1, 1'b0, 1'b0);
    run_and_check(12'hABC, 2'b10, 1, 1'b0, 1'b0);
    run_and_check(12'hABC, 2'b11, 1, 1'b0, 1'b0);

    // R7 long inhibit
    x_val = 12'h3C5; sel = 2'b00; start = 1'b1;
    @(negedge clk); @(negedge clk);
    start = 1'b0; inhibit = 1'b1;
    p = 0;
    repeat (20) begin @(negedge clk); if (cclk) p++; end
    chk(p == 0, "R7", "clock held under inhibit", p, 0);
    chk(data == '1 && busy, "R7", "result frozen", int'(data), 'hFFF);
    inhibit = 1'b0;
    g = 0;
    while (busy && g < 1000) begin @(negedge clk); g++; end
    chk(data == 12'h3C5, "R7", "result after release", int'(data), 'h3C5);

    // R9 restart during run
    run_and_check(12'h3C5, 2'b00, 1, 1'b0, 1'b1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      run_and_check(12'($urandom), 2'($urandom), 1 + int'($urandom % 4),
                    1'b1, ($urandom % 4) == 0);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule